// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block gathers 64 interrupt inputs into a single request line. Each input has a small byte-wide configuration slot. The slot holds an enable flag and a trigger selection: active-high level, rising edge or falling edge. Inputs are synchronised to the controller clock and checked for edges. Edge events are latched into two 32-bit status words. Software acknowledges an edge event by writing a one to its status bit. A level source has no latch and is quietened by disabling it.

The arbiter picks one winner among the pending, enabled sources. Its index is shown on a port and in a read-only register. Fixed mode always favours the lowest index. Rotating mode makes the most recently acknowledged source the least favoured, and the search resumes just after it. All configuration goes through a simple register bus that supports both single-byte and aligned 32-bit word accesses.

Top module: `intc_rot`

## Requirements
- R1: After reset, every source slot reads 0x00, both status words read zero, the word at 0x24 reads zero, rotating mode is off and `irq_o` is low.
- R2: The slot for source n is the byte at address 0x40+n. Bit 3 of the slot enables the source. A disabled source never drives `irq_o` and is never reported as the winner.
- R3: Slot bits 5:4 select the trigger: 0 is level-high, 1 is rising edge, 2 is falling edge, and 3 behaves as rising edge. The opposite edge latches nothing.
- R4: A level source enabled with its input high raises `irq_o` on the third rising clock edge after the input changes. It has no latch, so it stops pending once the input falls.
- R5: An edge event sets bit n%32 of the status word at 0x80 (sources 0-31) or 0x84 (sources 32-63), even while the source is disabled. An enabled edge source raises `irq_o` on the fourth clock edge after the input transition. A level-mode source never sets its status bit.
- R6: Writing a one to a status bit clears that latched event. Writing a zero leaves the bit unchanged.
- R7: With rotating mode off, the lowest-numbered pending and enabled source wins.
- R8: Bit 6 of the word at 0x20 turns on rotating mode. Two writes count as acknowledging the current winner: a status write with a one at the winner's bit, and a slot write that clears the winner's enable. After an acknowledgement, the search starts at the next index (wrapping from 63 to 0), so the acknowledged source becomes the lowest priority.
- R9: The read-only byte at 0x88 returns the winner index in bits 5:0 and a valid flag in bit 7. `irq_id_o` carries the same index, and `irq_o` equals the valid flag.
- R10: A byte access (`bus_word_i`=0) uses bits 7:0 of the data at any address. A word access uses address bits 7:2, with the lowest address in data bits 7:0. Slot bits other than 5:3 read as zero. The word at 0x24 is plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Asynchronous interrupt inputs |
| bus_req_i | input | 1 | Bus access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_word_i | input | 1 | 1 = aligned 32-bit access, 0 = byte access |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| irq_o | output | 1 | Interrupt request |
| irq_id_o | output | 6 | Index of the winning source |

## Verification
Several properties are checked on every cycle. The reported winner is always a pending source that was enabled. In fixed mode, no lower-numbered source is pending while another wins. A source in level mode never gains a status bit. The request is low during reset. Some behaviour shows only in the bench's scenarios: the exact latencies, the edge polarity per trigger code, the clearing behaviour of status writes, the rotation order across acknowledgements including the wrap from 63 to 0, and byte-lane mapping on word accesses.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_RISE  = 2'd1,
    TRIG_FALL  = 2'd2,
    TRIG_RSVD  = 2'd3
  } trig_e;

  localparam logic [7:0] ADDR_PRIO = 8'h20;
  localparam logic [7:0] ADDR_AUX  = 8'h24;
  localparam logic [7:0] ADDR_CTRL = 8'h40;
  localparam logic [7:0] ADDR_STAT = 8'h80;
  localparam logic [7:0] ADDR_WIN  = 8'h88;
  localparam int EN_BIT  = 3;
  localparam int ROT_BIT = 6;
  localparam int LANES   = 4;
endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell
  import intc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       src_i,
  input  logic [1:0] trig_i,
  input  logic       en_i,
  input  logic       clr_i,
  output logic       stat_o,
  output logic       pend_o
);
  logic s1_q, s2_q, s3_q, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0; s2_q <= 1'b0; s3_q <= 1'b0;
    end else begin
      s1_q <= src_i; s2_q <= s1_q; s3_q <= s2_q;
    end
  end

  always_comb begin
    unique case (trig_e'(trig_i))
      TRIG_LEVEL: hit = 1'b0;
      TRIG_FALL:  hit = ~s2_q & s3_q;
      default:    hit = s2_q & ~s3_q; // rise and reserved code
    endcase
  end

  // new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      if (hit) stat_o <= 1'b1;
      else if (clr_i) stat_o <= 1'b0;
      pend_o <= en_i & ((trig_i == TRIG_LEVEL) ? s2_q : stat_o);
    end
  end
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int N = 64,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] base_i,
  output logic [W-1:0] id_o,
  output logic         vld_o
);
  // N must be a power of two so index arithmetic wraps
  always_comb begin
    logic [W-1:0] idx;
    logic         found;
    id_o  = '0;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      idx = base_i + W'(k);
      if (!found && req_i[idx]) begin
        id_o  = idx;
        found = 1'b1;
      end
    end
    vld_o = found;
  end
endmodule

// File: rtl/intc_rot.sv
module intc_rot
  import intc_pkg::*;
#(
  parameter int N_SRC = 64,
  localparam int ID_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic             bus_word_i,
  input  logic [7:0]       bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  output logic             irq_o,
  output logic [ID_W-1:0]  irq_id_o
);
  logic [N_SRC-1:0] en_q, clr, dis, stat_v, pend_q, lvl_v;
  logic [1:0]       mode_q [N_SRC];
  logic             rot_q;
  logic [31:0]      aux_q;
  logic [ID_W-1:0]  ptr_q, base, win_id;
  logic             win_vld, ack;
  logic [63:0]      stat_w;
  logic [7:0]       ln_addr [LANES];
  logic [7:0]       ln_data [LANES];
  logic [7:0]       rd_b    [LANES];
  logic [LANES-1:0] ln_en;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      ln_addr[l] = bus_word_i ? {bus_addr_i[7:2], 2'(l)} : bus_addr_i;
      ln_data[l] = bus_word_i ? bus_wdata_i[8*l +: 8] : bus_wdata_i[7:0];
      ln_en[l]   = bus_req_i & bus_we_i & (bus_word_i | (l == 0));
    end
  end

  // status clears and enable drops, per source
  always_comb begin
    clr = '0;
    dis = '0;
    for (int n = 0; n < N_SRC; n++) begin
      lvl_v[n] = (mode_q[n] == TRIG_LEVEL);
      for (int l = 0; l < LANES; l++) begin
        if (ln_en[l] && ln_addr[l] == ADDR_STAT + 8'(n / 8) && ln_data[l][n % 8])
          clr[n] = 1'b1;
        if (ln_en[l] && ln_addr[l] == ADDR_CTRL + 8'(n) && !ln_data[l][EN_BIT])
          dis[n] = 1'b1;
      end
    end
  end

  assign base = rot_q ? ptr_q + ID_W'(1) : '0;
  assign ack  = win_vld & (clr[win_id] | dis[win_id]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      rot_q <= 1'b0;
      aux_q <= '0;
      ptr_q <= '1;
      for (int n = 0; n < N_SRC; n++) mode_q[n] <= 2'd0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (ln_en[l]) begin
          if (ln_addr[l] == ADDR_PRIO) rot_q <= ln_data[l][ROT_BIT];
          if (ln_addr[l][7:2] == ADDR_AUX[7:2]) aux_q[8*ln_addr[l][1:0] +: 8] <= ln_data[l];
          for (int n = 0; n < N_SRC; n++) begin
            if (ln_addr[l] == ADDR_CTRL + 8'(n)) begin
              en_q[n]   <= ln_data[l][EN_BIT];
              mode_q[n] <= ln_data[l][5:4];
            end
          end
        end
      end
      if (ack) ptr_q <= win_id;
    end
  end

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    intc_src_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .src_i (src_i[n]),
      .trig_i(mode_q[n]),
      .en_i  (en_q[n]),
      .clr_i (clr[n]),
      .stat_o(stat_v[n]),
      .pend_o(pend_q[n])
    );
  end

  intc_pick #(.N(N_SRC)) u_pick (
    .req_i (pend_q),
    .base_i(base),
    .id_o  (win_id),
    .vld_o (win_vld)
  );

  assign stat_w = 64'(stat_v);

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rd_b[l] = '0;
      if (ln_addr[l] == ADDR_PRIO)
        rd_b[l][ROT_BIT] = rot_q;
      else if (ln_addr[l][7:2] == ADDR_AUX[7:2])
        rd_b[l] = aux_q[8*ln_addr[l][1:0] +: 8];
      else if (ln_addr[l][7:6] == 2'b01) begin
        if (int'(ln_addr[l][5:0]) < N_SRC)
          rd_b[l] = {2'b00, mode_q[ln_addr[l][5:0]], en_q[ln_addr[l][5:0]], 3'b000};
      end else if (ln_addr[l][7:3] == ADDR_STAT[7:3])
        rd_b[l] = stat_w[8*ln_addr[l][2:0] +: 8];
      else if (ln_addr[l] == ADDR_WIN)
        rd_b[l] = {win_vld, 1'b0, 6'(win_id)};
    end
    bus_rdata_o = bus_word_i ? {rd_b[3], rd_b[2], rd_b[1], rd_b[0]} : {24'b0, rd_b[0]};
  end

  assign irq_o    = win_vld;
  assign irq_id_o = win_id;
endmodule

// File: rtl/intc_rot_chk.sv
module intc_rot_chk #(
  parameter int N = 64,
  parameter int W = 6
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         irq_o,
  input logic [W-1:0] irq_id_o,
  input logic [N-1:0] en_q,
  input logic [N-1:0] pend_q,
  input logic [N-1:0] stat_v,
  input logic [N-1:0] lvl_v,
  input logic         rot_q
);
  logic [N-1:0] en_d, stat_d, lvl_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d <= '0; stat_d <= '0; lvl_d <= '0;
    end else begin
      en_d <= en_q; stat_d <= stat_v; lvl_d <= lvl_v;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> !irq_o);

  // R2
  winner_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en_d[irq_id_o]);

  // R9
  winner_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_q[irq_id_o]);

  // R7
  fixed_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rot_q) |-> ((pend_q & ((N'(1) << irq_id_o) - N'(1))) == '0));

  // R5
  level_no_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_v & ~stat_d & lvl_d) == '0);
endmodule

bind intc_rot intc_rot_chk #(.N(N_SRC), .W(ID_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .irq_id_o(irq_id_o),
  .en_q    (en_q),
  .pend_q  (pend_q),
  .stat_v  (stat_v),
  .lvl_v   (lvl_v),
  .rot_q   (rot_q)
);

// File: tb/intc_rot_test.sv
module intc_rot_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        req = 1'b0, we = 1'b0, word = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [5:0]  irq_id;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  intc_rot uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .bus_req_i(req), .bus_we_i(we), .bus_word_i(word),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .irq_id_o(irq_id)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic w);
    @(negedge clk);
    req = 1'b1; we = 1'b1; word = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic w, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; word = w; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_win(input string tag, input int id);
    logic [31:0] v;
    rd(8'h88, 1'b0, v);
    chk(tag, v, 32'h80 | 32'(id));
    chk(tag, {26'b0, irq_id}, 32'(id));
    chk(tag, {31'b0, irq}, 32'd1);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    int ids[4];
    waitc(3);
    rst_n = 1'b1;
    waitc(2);

    // R1 reset state
    for (int n = 0; n < 64; n++) begin
      rd(8'h40 + 8'(n), 1'b0, v);
      chk("R1 slot", v, 32'h0);
    end
    rd(8'h80, 1'b1, v); chk("R1 stat0", v, 0);
    rd(8'h84, 1'b1, v); chk("R1 stat1", v, 0);
    rd(8'h24, 1'b1, v); chk("R1 aux", v, 0);
    rd(8'h20, 1'b1, v); chk("R1 prio", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R4 level sweep, R2 disable masks
    for (int n = 0; n < 64; n++) begin
      wr(8'h40 + 8'(n), 32'h08, 1'b0);
      src[n] = 1'b1;
      waitc(2);
      chk("R4 latency", {31'b0, irq}, 0);
      waitc(1);
      chk_win("R4 R9 level", n);
      wr(8'h40 + 8'(n), 32'h00, 1'b0);
      waitc(3);
      chk("R2 disabled", {31'b0, irq}, 0);
      src[n] = 1'b0;
      wr(8'h40 + 8'(n), 32'h08, 1'b0);
      waitc(4);
      chk("R4 no latch", {31'b0, irq}, 0);
      wr(8'h40 + 8'(n), 32'h00, 1'b0);
    end

    // R3 R5 R6 edge sweep
    for (int m = 1; m < 4; m++) begin
      for (int n = 0; n < 64; n++) begin
        logic [7:0] sa;
        logic [31:0] bit_n;
        sa = 8'h80 + 8'(4 * (n / 32));
        bit_n = 32'(1) << (n % 32);
        src[n] = (m == 2);
        waitc(3);
        wr(8'h40 + 8'(n), 32'(m) << 4, 1'b0);
        waitc(3);
        src[n] = (m != 2);
        waitc(5);
        rd(sa, 1'b1, v);
        chk("R3 R5 latch", v, bit_n);
        chk("R5 disabled", {31'b0, irq}, 0);
        wr(8'h40 + 8'(n), (32'(m) << 4) | 32'h08, 1'b0);
        waitc(2);
        chk_win("R5 edge", n);
        wr(sa, ~bit_n, 1'b1);
        rd(sa, 1'b1, v);
        chk("R6 zero", v, bit_n);
        wr(sa, bit_n, 1'b1);
        rd(sa, 1'b1, v);
        chk("R6 clear", v, 0);
        waitc(2);
        chk("R6 irq", {31'b0, irq}, 0);
        src[n] = (m == 2);
        waitc(5);
        rd(sa, 1'b1, v);
        chk("R3 polarity", v, 0);
        wr(8'h40 + 8'(n), 32'h00, 1'b0);
        src[n] = 1'b0;
        waitc(3);
      end
    end

    // R7 fixed priority
    ids = '{5, 10, 20, 47};
    foreach (ids[i]) begin
      wr(8'h40 + 8'(ids[i]), 32'h08, 1'b0);
      src[ids[i]] = 1'b1;
    end
    waitc(4);
    chk_win("R7 lowest", 5);
    wr(8'h45, 32'h00, 1'b0);
    waitc(3);
    chk_win("R7 next", 10);
    foreach (ids[i]) begin
      wr(8'h40 + 8'(ids[i]), 32'h00, 1'b0);
      src[ids[i]] = 1'b0;
    end
    waitc(3);

    // R8 rotating
    wr(8'h20, 32'h40, 1'b1);
    rd(8'h20, 1'b1, v); chk("R8 prio reg", v, 32'h40);
    wr(8'h40 + 8'd30, 32'h08, 1'b0);
    src[30] = 1'b1;
    waitc(4);
    chk_win("R8 single", 30);
    wr(8'h40 + 8'd30, 32'h00, 1'b0);
    src[30] = 1'b0;
    ids = '{5, 10, 20, 40};
    foreach (ids[i]) begin
      wr(8'h40 + 8'(ids[i]), 32'h08, 1'b0);
      src[ids[i]] = 1'b1;
    end
    waitc(4);
    chk_win("R8 after 30", 40);
    wr(8'h40 + 8'd40, 32'h00, 1'b0);
    wr(8'h40 + 8'd40, 32'h08, 1'b0);
    waitc(3);
    chk_win("R8 wrap", 5);
    wr(8'h45, 32'h00, 1'b0);
    wr(8'h45, 32'h08, 1'b0);
    waitc(3);
    chk_win("R8 after 5", 10);
    wr(8'h4A, 32'h00, 1'b0);
    wr(8'h4A, 32'h08, 1'b0);
    waitc(3);
    chk_win("R8 after 10", 20);
    wr(8'h40 + 8'd20, 32'h00, 1'b0);
    wr(8'h40 + 8'd20, 32'h08, 1'b0);
    waitc(3);
    chk_win("R8 after 20", 40);
    wr(8'h45, 32'h00, 1'b0);
    wr(8'h4A, 32'h00, 1'b0);
    wr(8'h40 + 8'd20, 32'h00, 1'b0);
    wr(8'h40 + 8'd40, 32'h00, 1'b0);
    src = '0;
    waitc(4);
    chk("R8 idle", {31'b0, irq}, 0);
    // edge acks, pointer now at 40
    wr(8'h43, 32'h18, 1'b0);
    wr(8'h40 + 8'd40, 32'h18, 1'b0);
    waitc(2);
    src[3] = 1'b1; src[40] = 1'b1;
    waitc(5);
    chk_win("R8 edge start", 3);
    wr(8'h80, 32'h8, 1'b1);
    waitc(2);
    chk_win("R8 edge ack", 40);
    src[3] = 1'b0;
    waitc(3);
    src[3] = 1'b1;
    waitc(5);
    chk_win("R8 reraise", 40);
    wr(8'h85, 32'h01, 1'b0); // byte W1C of source 40
    waitc(2);
    chk_win("R8 byte ack", 3);
    wr(8'h80, 32'hFFFF_FFFF, 1'b1);
    wr(8'h84, 32'hFFFF_FFFF, 1'b1);
    wr(8'h43, 32'h00, 1'b0);
    wr(8'h40 + 8'd40, 32'h00, 1'b0);
    src = '0;
    wr(8'h20, 32'h0, 1'b1);
    waitc(3);
    chk("R8 off", {31'b0, irq}, 0);

    // R10 bus lanes
    wr(8'h44, 32'h3F2A_1C08, 1'b1);
    rd(8'h44, 1'b1, v); chk("R10 word", v, 32'h3828_1808);
    rd(8'h46, 1'b0, v); chk("R10 byte", v, 32'h28);
    wr(8'h44, 32'h0, 1'b1);
    wr(8'h24, 32'hA5A5_1234, 1'b1);
    wr(8'h26, 32'h77, 1'b0);
    rd(8'h24, 1'b1, v); chk("R10 aux", v, 32'hA577_1234);
    rd(8'h27, 1'b0, v); chk("R10 aux byte", v, 32'hA5);

    summary();
  end
endmodule